// File: doc/BRIEF.md
# Interval Down-Counter Timer with Count Capture

A bus-attached interval timer that counts down from a 32-bit period and raises a level interrupt when it times out. Software sets the period in two 16-bit halves through a single-cycle register bus. Writing either half reloads the live count at once. Software then starts or stops the counter, chooses one-shot or continuous operation, and reads the live count back.

The count moves only on cycles where `tick_i` is high, so the counting rate is set outside the block. Each counting tick takes two off the count. When the count reaches zero, the period is reloaded and a sticky timeout flag is set. The interrupt follows the timeout flag when the interrupt-enable control bit is set. Software clears the flag by writing the status register.

Top module: `ivt_timer`

## Requirements
- R1: After reset every register reads zero, the count and period are zero, and `irq_o` is low.
- R2: Registers sit at `BASE_ADDR + 4*index`. The index order is status 0, control 1, count-low 2, count-high 3, capture-low 4, capture-high 5. Any address outside these six words reads zero and a write to it changes nothing.
- R3: Status implements 2 bits and control implements 4 bits. The other registers implement 16 bits each. Unimplemented bits read zero. Status bit 1 is read-only and shows RUN, which equals START and not STOP. Control bit 0 is IRQ_EN, bit 1 is CONT, bit 2 is START and bit 3 is STOP.
- R4: A write to index 2 replaces period bits 15:0, and a write to index 3 replaces period bits 31:16. Either write loads the count with the new full period at the same clock edge. Indices 2 and 3 read the live count, low half and high half.
- R5: On a clock edge with `tick_i` high, START set and STOP clear, the count falls by 2, with a floor at 0 when the count is 2 or less. Without such a tick the count holds.
- R6: When a counting tick brings the count to 0, the count is reloaded with the period and status bit 0 (TIMEOUT) is set.
- R7: When the count equals the period and CONT is clear, ticks leave the count unchanged. This gives one-shot operation.
- R8: A read of index 4 or index 5 returns the low or high half of the count held at the moment of the read.
- R9: `irq_o` is high exactly while IRQ_EN and TIMEOUT are both set. A status write with bit 0 at 0 clears TIMEOUT. A status write with bit 0 at 1 leaves it unchanged.
- R10: A period write in the same cycle as a counting tick takes precedence. The count takes the new period and no timeout is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count enable for this cycle |
| addr_i | input | ADDR_W | Byte address of the register access |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, combinational in the read cycle |
| irq_o | output | 1 | Level interrupt |

## Verification
Read data is combinational, so the bench samples `rdata_o` in the same cycle it raises `re_i`, shortly after the falling edge. Writes, ticks, the reload and TIMEOUT all take effect at the next rising edge. The bench therefore checks them at the falling edge after that edge. `irq_o` is a gate of two registered bits, so it is due one edge after the status or control write that changes it. Each scenario drives one-cycle strobes and counts ticks exactly, so every expected count is worked out from the period and the number of counting edges.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int unsigned NUM_REGS = 6;
  localparam int unsigned IDX_W    = $clog2(NUM_REGS);
  localparam int unsigned CNT_W    = 32;
  localparam int unsigned HALF_W   = CNT_W / 2;
  localparam int unsigned CTRL_W   = 4;

  typedef enum logic [IDX_W-1:0] {
    REG_STAT = 3'd0,
    REG_CTRL = 3'd1,
    REG_CLO  = 3'd2,
    REG_CHI  = 3'd3,
    REG_SLO  = 3'd4,
    REG_SHI  = 3'd5
  } reg_idx_e;

  localparam int unsigned C_IRQ_EN = 0;
  localparam int unsigned C_CONT   = 1;
  localparam int unsigned C_START  = 2;
  localparam int unsigned C_STOP   = 3;
endpackage

// File: rtl/ivt_decode.sv
module ivt_decode
  import ivt_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_REGS-1:0] sel_o
);
  localparam logic [ADDR_W:0] END_ADDR = {1'b0, BASE_ADDR} + (NUM_REGS * 4);

  logic [ADDR_W-1:0] offset;
  logic              hit;
  logic [IDX_W-1:0]  idx;
  logic              unused_low;

  assign offset     = addr_i - BASE_ADDR;
  assign hit        = (addr_i >= BASE_ADDR) && ({1'b0, addr_i} < END_ADDR);
  assign idx        = offset[IDX_W+1:2];
  assign unused_low = ^{offset[1:0], offset[ADDR_W-1:IDX_W+2]};

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign sel_o[g] = hit && (idx == IDX_W'(g));
  end

  // R2
  always_comb begin
    one_sel_chk: assert ($onehot0(sel_o));
  end
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter
  import ivt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              cont_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              timeout_o
);
  logic [CNT_W-1:0] period_q, period_d, count_q, dec;
  logic             wr, enabled, hold, step;

  assign wr = wr_lo_i | wr_hi_i;

  always_comb begin
    period_d = period_q;
    if (wr_lo_i) period_d[HALF_W-1:0]     = wdata_i;
    if (wr_hi_i) period_d[CNT_W-1:HALF_W] = wdata_i;
  end

  assign enabled   = start_i & ~stop_i;
  assign hold      = (count_q == period_q) & ~cont_i;
  assign step      = tick_i & enabled & ~hold;
  assign dec       = (count_q > CNT_W'(2)) ? count_q - CNT_W'(2) : '0;
  assign timeout_o = step & ~wr & (dec == '0);
  assign count_o   = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      count_q  <= '0;
    end else if (wr) begin
      period_q <= period_d;
      count_q  <= period_d;
    end else if (step) begin
      count_q  <= (dec == '0) ? period_q : dec;
    end
  end

  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr) |=> $stable(count_q));
  // R5
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !wr) |=> $stable(count_q));
  // R4
  wr_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr |=> (count_q == period_q));
  // R6
  to_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> (count_q == period_q));
  // R7
  oneshot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((count_q == period_q) && !cont_i && !wr) |=> $stable(count_q));
endmodule

// File: rtl/ivt_csr.sv
module ivt_csr
  import ivt_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_REGS-1:0] sel_i,
  input  logic                we_i,
  input  logic                re_i,
  input  logic [31:0]         wdata_i,
  input  logic [CNT_W-1:0]    count_i,
  input  logic                timeout_i,
  output logic [CTRL_W-1:0]   ctrl_o,
  output logic [31:0]         rdata_o,
  output logic                irq_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              to_q, run, unused_hi;
  logic [31:0]       rd_mux;

  assign unused_hi = ^wdata_i[31:CTRL_W];
  assign run       = ctrl_q[C_START] & ~ctrl_q[C_STOP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      to_q   <= 1'b0;
    end else begin
      if (we_i && sel_i[REG_CTRL]) ctrl_q <= wdata_i[CTRL_W-1:0];
      // a timeout in the same cycle beats a software clear
      if (timeout_i)                                  to_q <= 1'b1;
      else if (we_i && sel_i[REG_STAT] && !wdata_i[0]) to_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      sel_i[REG_STAT]: rd_mux = {30'd0, run, to_q};
      sel_i[REG_CTRL]: rd_mux = {{(32-CTRL_W){1'b0}}, ctrl_q};
      sel_i[REG_CLO],
      sel_i[REG_SLO]:  rd_mux = {16'd0, count_i[HALF_W-1:0]};
      sel_i[REG_CHI],
      sel_i[REG_SHI]:  rd_mux = {16'd0, count_i[CNT_W-1:HALF_W]};
      default:         rd_mux = '0;
    endcase
  end

  assign rdata_o = re_i ? rd_mux : '0;
  assign ctrl_o  = ctrl_q;
  assign irq_o   = ctrl_q[C_IRQ_EN] & to_q;

  // R9
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i[REG_STAT] && !wdata_i[0] && !timeout_i) |=> !irq_o);
  // R6
  to_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_i |=> to_q);
  // R9
  irq_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(we_i && (sel_i[REG_STAT] || sel_i[REG_CTRL]))) |=> irq_o);
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
  import ivt_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  input  logic              re_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  logic [NUM_REGS-1:0] sel;
  logic [CTRL_W-1:0]   ctrl;
  logic [CNT_W-1:0]    count;
  logic                timeout;

  ivt_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  ivt_counter u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .start_i   (ctrl[C_START]),
    .stop_i    (ctrl[C_STOP]),
    .cont_i    (ctrl[C_CONT]),
    .wr_lo_i   (we_i & sel[REG_CLO]),
    .wr_hi_i   (we_i & sel[REG_CHI]),
    .wdata_i   (wdata_i[HALF_W-1:0]),
    .count_o   (count),
    .timeout_o (timeout)
  );

  ivt_csr u_csr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel),
    .we_i      (we_i),
    .re_i      (re_i),
    .wdata_i   (wdata_i),
    .count_i   (count),
    .timeout_i (timeout),
    .ctrl_o    (ctrl),
    .rdata_o   (rdata_o),
    .irq_o     (irq_o)
  );
endmodule

// File: tb/ivt_timer_bench.sv
`timescale 1ns/1ps
module ivt_timer_bench;
  localparam logic [7:0] BASE = 8'h40;
  localparam logic [7:0] A_ST = BASE, A_CT = BASE + 8'd4, A_LO = BASE + 8'd8,
                         A_HI = BASE + 8'd12, A_SL = BASE + 8'd16, A_SH = BASE + 8'd20;

  logic clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, we_i = 1'b0, re_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  ivt_timer #(.ADDR_W(8), .BASE_ADDR(BASE)) u_ivt_timer (.*);

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i); we_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr_i = a; re_i = 1'b1; #1 d = rdata_o;
    @(negedge clk_i); re_i = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d); chk(req, d, exp);
  endtask

  task automatic ticks(int n);
    tick_i = 1'b1; repeat (n) @(negedge clk_i); tick_i = 1'b0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 6; i++) rd_chk("R1", BASE + 8'(4 * i), 32'h0);
    chk("R1 irq", {31'd0, irq_o}, 32'h0);
  endtask

  task automatic t_mask();
    wr(A_CT, 32'hFFFF_FFFF);
    rd_chk("R3 ctrl mask", A_CT, 32'hF);
    rd_chk("R3 run off", A_ST, 32'h0);
    wr(A_CT, 32'h4);
    rd_chk("R3 run on", A_ST, 32'h2);
    wr(A_ST, 32'hFFFF_FFFC);
    rd_chk("R3 status ro", A_ST, 32'h2);
    wr(A_CT, 32'h0);
  endtask

  task automatic t_period();
    wr(A_LO, 32'h1234_ABCD);
    rd_chk("R4 lo", A_LO, 32'hABCD);
    rd_chk("R4 hi", A_HI, 32'h0);
    wr(A_HI, 32'hFFFF_0002);
    rd_chk("R4 hi2", A_HI, 32'h2);
    rd_chk("R4 lo2", A_LO, 32'hABCD);
  endtask

  task automatic t_count();
    wr(A_CT, 32'h6);
    ticks(3);
    rd_chk("R5 dec", A_LO, 32'hABC7);
    rd_chk("R8 cap lo", A_SL, 32'hABC7);
    rd_chk("R8 cap hi", A_SH, 32'h2);
    rd_chk("R5 no tick", A_LO, 32'hABC7);
    wr(A_CT, 32'hE);
    ticks(2);
    rd_chk("R5 stop", A_LO, 32'hABC7);
    rd_chk("R3 run stop", A_ST, 32'h0);
  endtask

  task automatic t_timeout();
    wr(A_HI, 32'h0);
    wr(A_LO, 32'h5);
    wr(A_CT, 32'h6);
    ticks(2);
    rd_chk("R5 floor pre", A_LO, 32'h1);
    rd_chk("R6 no to", A_ST, 32'h2);
    ticks(1);
    rd_chk("R6 reload", A_LO, 32'h5);
    rd_chk("R6 to set", A_ST, 32'h3);
    chk("R9 irq masked", {31'd0, irq_o}, 32'h0);
    wr(A_CT, 32'h7);
    chk("R9 irq on", {31'd0, irq_o}, 32'h1);
    wr(A_ST, 32'h1);
    chk("R9 write one", {31'd0, irq_o}, 32'h1);
    wr(A_ST, 32'h0);
    chk("R9 cleared", {31'd0, irq_o}, 32'h0);
    rd_chk("R9 status", A_ST, 32'h2);
    wr(A_LO, 32'h4);
    ticks(1);
    rd_chk("R5 four", A_LO, 32'h2);
    ticks(1);
    rd_chk("R5 floor", A_LO, 32'h4);
    chk("R6 irq", {31'd0, irq_o}, 32'h1);
    wr(A_ST, 32'h0);
  endtask

  task automatic t_oneshot();
    wr(A_CT, 32'h5);
    wr(A_LO, 32'h8);
    ticks(3);
    rd_chk("R7 hold", A_LO, 32'h8);
    chk("R7 no irq", {31'd0, irq_o}, 32'h0);
    wr(A_CT, 32'h7);
    ticks(1);
    wr(A_CT, 32'h5);
    rd_chk("R7 cont", A_LO, 32'h6);
    ticks(3);
    rd_chk("R7 reload", A_LO, 32'h8);
    ticks(2);
    rd_chk("R7 rehold", A_LO, 32'h8);
    chk("R7 irq", {31'd0, irq_o}, 32'h1);
  endtask

  task automatic t_range();
    wr(BASE + 8'd24, 32'h0);
    wr(BASE - 8'd4, 32'h0);
    rd_chk("R2 ctrl kept", A_CT, 32'h5);
    rd_chk("R2 status kept", A_ST, 32'h3);
    rd_chk("R2 above", BASE + 8'd24, 32'h0);
    rd_chk("R2 below", BASE - 8'd4, 32'h0);
    wr(A_ST, 32'h0);
  endtask

  task automatic t_collide();
    wr(A_CT, 32'h7);
    addr_i = A_LO; wdata_i = 32'd20; we_i = 1'b1; tick_i = 1'b1;
    @(negedge clk_i); we_i = 1'b0; tick_i = 1'b0;
    rd_chk("R10 write wins", A_LO, 32'd20);
    ticks(1);
    rd_chk("R10 next", A_LO, 32'd18);
    chk("R10 no to", {31'd0, irq_o}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_mask();
    t_period();
    t_count();
    t_timeout();
    t_oneshot();
    t_range();
    t_collide();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk_i);
        total++; bad++;
        $display("FAIL watchdog got=running exp=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule